// File: doc/BRIEF.md
# Vectored Interrupt Address Remapper

This block sits on the address path between a 6502-class processor and its memory. It lets eight prioritized interrupt lines each have their own handler vector. The processor still performs its normal IRQ vector fetch from the last word of the top page. The block detects that fetch and rewrites the low address bits, so the two vector bytes are read from a per-level slot lower in the same page. The highest-priority level gets the lowest slot.

The requests pass through a freeze register. It follows the request lines while the vector-pull strobe is idle and holds its contents while the strobe is active. Because of this, the low and high vector bytes always come from the same level, even if a higher request arrives between the two reads. The combined interrupt line to the processor is formed from the live request lines. Reset and NMI vector fetches are recognised by their address and are never rewritten.

Top module: `vec_irq_remap`

## Requirements
- R1: `cpu_irq_n` is low in the same cycle whenever at least one bit of `irq_n` is low, and high when all bits are high.
- R2: While `vp_n` is high, `addr_o` equals `addr_i` on every bit.
- R3: While `vp_n` is low and address bits 2 and 1 are not both 1, `addr_o` equals `addr_i`. This covers the reset vector (FFFC/FFFD) and the NMI vector (FFFA/FFFB).
- R4: While `vp_n` is low, address bits 2 and 1 are both 1, and the frozen requests hold an active level L, `addr_o` = FFE0 + 2*(7-L) + `addr_i[0]`. Bits 15..5 come from `addr_i`, bit 4 is 0, bits 3..1 are 7-L, and bit 0 is passed through.
- R5: Among the active frozen requests, the highest index wins. Level 7 maps to FFE0/FFE1 and level 0 maps to FFEE/FFEF.
- R6: The freeze register loads the inverted `irq_n` at every rising clock edge where `vp_n` is high. It keeps its value at edges where `vp_n` is low, so both vector bytes come from one level.
- R7: During an IRQ vector fetch with no active frozen request (for example a BRK), `addr_o` equals `addr_i` (FFFE/FFFF).
- R8: While `rst_n` is low, the freeze register holds no active request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Address from the processor |
| vp_n | input | 1 | Active-low vector-pull strobe |
| irq_n | input | 8 | Active-low interrupt requests, index 7 highest |
| addr_o | output | 16 | Address toward memory |
| cpu_irq_n | output | 1 | Active-low combined interrupt request |

## Verification
`cpu_irq_n` and `addr_o` are combinational from the live inputs and the freeze register. The bench therefore drives stimulus on the falling clock edge and checks a short time later, in the same half cycle. A new request level reaches the freeze register only at the next rising edge where `vp_n` is high. Each vector-fetch check is therefore placed after at least one such edge. The freeze test changes the requests while `vp_n` is low and lets an edge pass before it reads the high byte.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
   // slot index of a level inside the vector table: top level sits lowest
   function automatic int unsigned slot_of(input int unsigned lvl, input int unsigned nlvl);
      return nlvl - 1 - lvl;
   endfunction
endpackage

// File: rtl/irq_freeze_reg.sv
module irq_freeze_reg #(
   parameter int NUM_LVL = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic [NUM_LVL-1:0] req_i,
   output logic [NUM_LVL-1:0] req_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     req_q <= '0;
      else if (!hold) req_q <= req_i;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] req,
   output logic [LVL_W-1:0]   level,
   output logic               valid
);
   always_comb begin
      level = '0;
      valid = 1'b0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (req[i]) begin
            level = LVL_W'(i);
            valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vec_addr_sub.sv
module vec_addr_sub #(
   parameter int ADDR_W  = 16,
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              vp_n,
   input  logic [LVL_W-1:0]  level,
   input  logic              valid,
   output logic [ADDR_W-1:0] addr_o
);
   logic irq_fetch;
   logic [LVL_W-1:0] slot;

   assign irq_fetch = !vp_n && addr_i[2] && addr_i[1];
   assign slot      = LVL_W'(irq_remap_pkg::slot_of(int'(level), NUM_LVL));

   always_comb begin
      addr_o = addr_i;
      if (irq_fetch && valid) begin
         addr_o[LVL_W+1] = 1'b0;
         addr_o[LVL_W:1] = slot;
      end
   end
endmodule

// File: rtl/vec_irq_remap.sv
module vec_irq_remap #(
   parameter int ADDR_W  = 16,
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               vp_n,
   input  logic [NUM_LVL-1:0] irq_n,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               cpu_irq_n
);
   generate
      if (NUM_LVL < 2 || (1 << LVL_W) != NUM_LVL) begin : g_bad_lvl
         $error("NUM_LVL must be a power of two of at least 2");
      end
      if (ADDR_W < LVL_W + 3) begin : g_bad_addr
         $error("ADDR_W too narrow for the vector table");
      end
   endgenerate

   logic [NUM_LVL-1:0] frz_req;
   logic [LVL_W-1:0]   level;
   logic               valid;

   assign cpu_irq_n = &irq_n;

   irq_freeze_reg #(.NUM_LVL(NUM_LVL)) frz_i (
      .clk(clk), .rst_n(rst_n), .hold(!vp_n), .req_i(~irq_n), .req_q(frz_req));

   irq_prio_enc #(.NUM_LVL(NUM_LVL)) enc_i (
      .req(frz_req), .level(level), .valid(valid));

   vec_addr_sub #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) sub_i (
      .addr_i(addr_i), .vp_n(vp_n), .level(level), .valid(valid), .addr_o(addr_o));
endmodule

// File: rtl/vec_irq_remap_chk.sv
module vec_irq_remap_chk #(
   parameter int ADDR_W  = 16,
   parameter int NUM_LVL = 8,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               vp_n,
   input logic [NUM_LVL-1:0] irq_n,
   input logic [ADDR_W-1:0]  addr_o,
   input logic               cpu_irq_n,
   input logic [NUM_LVL-1:0] frz_req
);
   logic fetch;
   assign fetch = !vp_n && addr_i[2] && addr_i[1];

   assert_irq_combine_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n != '1) |-> !cpu_irq_n);

   assert_pass_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vp_n |-> (addr_o == addr_i));

   assert_pass_other_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!vp_n && !(addr_i[2] && addr_i[1])) |-> (addr_o == addr_i));

   assert_remap_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && frz_req != '0) |->
         (addr_o[ADDR_W-1:LVL_W+2] == addr_i[ADDR_W-1:LVL_W+2]) &&
         !addr_o[LVL_W+1] && (addr_o[0] == addr_i[0]));

   assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!vp_n)) |-> $stable(frz_req));

   assert_brk_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && frz_req == '0) |-> (addr_o == addr_i));

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |-> (frz_req == '0));
endmodule

bind vec_irq_remap vec_irq_remap_chk #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) chk_i (
   .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .vp_n(vp_n), .irq_n(irq_n),
   .addr_o(addr_o), .cpu_irq_n(cpu_irq_n), .frz_req(frz_req));

// File: tb/vec_irq_remap_tb.sv
module vec_irq_remap_tb_top;
   localparam int CLK_P = 10;
   localparam int NV = 8;

   typedef struct packed {
      logic [7:0]  irq_n;
      logic [15:0] exp_lo;
   } vec_t;

   // request pattern and expected low-byte address (R4, R5)
   localparam vec_t VECS [NV] = '{
      '{8'hFE, 16'hFFEE}, '{8'h7F, 16'hFFE0}, '{8'hFB, 16'hFFEA}, '{8'h00, 16'hFFE0},
      '{8'hF5, 16'hFFE8}, '{8'hBF, 16'hFFE2}, '{8'hEF, 16'hFFE6}, '{8'hFD, 16'hFFEC}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr_i = 16'h0000;
   logic        vp_n = 1'b1;
   logic [7:0]  irq_n = 8'hFF;
   logic [15:0] addr_o;
   logic        cpu_irq_n;
   int checks = 0;
   int fails = 0;

   always #(CLK_P/2) clk = ~clk;

   vec_irq_remap dut_i (.clk(clk), .rst_n(rst_n), .addr_i(addr_i), .vp_n(vp_n),
      .irq_n(irq_n), .addr_o(addr_o), .cpu_irq_n(cpu_irq_n));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at falling edge, settle briefly
   task automatic drive(input logic vp, input logic [15:0] a, input logic [7:0] irq);
      @(negedge clk);
      vp_n = vp; addr_i = a; irq_n = irq;
      #2;
   endtask

   initial begin : watchdog
      #(CLK_P * 5000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // reset state: requests live, vector fetch under reset passes through
      drive(1'b0, 16'hFFFE, 8'h00);
      repeat (2) @(posedge clk);
      #2;
      chk("R8 reset pass", addr_o, 16'hFFFE);
      chk("R1 under reset", {15'd0, cpu_irq_n}, 16'd0);
      drive(1'b0, 16'hFFFE, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R6 hold after reset", addr_o, 16'hFFFE);

      // table walk
      for (int k = 0; k < NV; k++) begin
         drive(1'b1, 16'h1234 ^ 16'(k), VECS[k].irq_n);
         chk("R2 idle pass", addr_o, 16'h1234 ^ 16'(k));
         chk("R1 combine", {15'd0, cpu_irq_n}, 16'd0);
         drive(1'b0, 16'hFFFE, VECS[k].irq_n);
         chk("R4 R5 low byte", addr_o, VECS[k].exp_lo);
         drive(1'b0, 16'hFFFF, VECS[k].irq_n);
         chk("R4 R5 high byte", addr_o, VECS[k].exp_lo + 16'd1);
      end

      // BRK with no request
      drive(1'b1, 16'h8000, 8'hFF);
      chk("R1 idle high", {15'd0, cpu_irq_n}, 16'd1);
      drive(1'b0, 16'hFFFE, 8'hFF);
      chk("R7 brk low", addr_o, 16'hFFFE);
      drive(1'b0, 16'hFFFF, 8'hFF);
      chk("R7 brk high", addr_o, 16'hFFFF);

      // freeze across a late higher request
      drive(1'b1, 16'h0200, 8'hFE);
      drive(1'b0, 16'hFFFE, 8'hFE);
      chk("R6 frozen low", addr_o, 16'hFFEE);
      drive(1'b0, 16'hFFFF, 8'h7F);
      chk("R1 live while frozen", {15'd0, cpu_irq_n}, 16'd0);
      drive(1'b0, 16'hFFFF, 8'h7F);
      chk("R6 frozen high", addr_o, 16'hFFEF);
      drive(1'b1, 16'h0300, 8'h7F);
      drive(1'b0, 16'hFFFE, 8'h7F);
      chk("R6 recapture", addr_o, 16'hFFE0);

      // reset and NMI vectors untouched with requests active
      drive(1'b0, 16'hFFFA, 8'h7F);
      chk("R3 nmi low", addr_o, 16'hFFFA);
      drive(1'b0, 16'hFFFB, 8'h7F);
      chk("R3 nmi high", addr_o, 16'hFFFB);
      drive(1'b0, 16'hFFFC, 8'h7F);
      chk("R3 reset low", addr_o, 16'hFFFC);
      drive(1'b0, 16'hFFFD, 8'h7F);
      chk("R3 reset high", addr_o, 16'hFFFD);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule